// File: doc/BRIEF.md
# Table-Driven Decade Up/Down Counter

A synchronous counter that steps through the ten codes 0 to 9 and can run in either direction. No adder or subtractor sits in the feedback path. A constant lookup table decides every transition. The table holds one word for each combination of the present count and the direction bit, and each word supplies both the next count and a wrap flag. A four-bit register holds the present count and loads the selected word on every clock edge.

The table contents are computed during elaboration from the modulus parameter. Codes above the decade can never be produced by a legal transition. If such a code does appear, for example after an upset, the table sends it back to zero on the next edge. The wrap flag is combinational. It is high during the cycle in which the next edge will wrap the count, so a following stage can sample it on that same edge.

Top module: `decade_rom_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count` is 0 after that edge, whatever `countDown` is.
- R2: With `countDown` = 0 and a present count from 0 to 8, the next rising edge adds one to `count`.
- R3: With `countDown` = 0 and a present count of 9, `carry` is 1 during that cycle and the next edge sets `count` to 0.
- R4: With `countDown` = 1 and a present count from 1 to 9, the next rising edge subtracts one from `count`.
- R5: With `countDown` = 1 and a present count of 0, `carry` is 1 during that cycle and the next edge sets `count` to 9.
- R6: `carry` is 0 in every other combination of a legal count and direction.
- R7: A present count from 10 to 15 goes to 0 on the next edge in either direction, and `carry` stays 0 while that code is present.
- R8: A change of `countDown` takes effect at the very next edge, so the counter can reverse in the middle of the sequence without skipping a code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| countDown | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | 4 | Present count |
| carry | output | 1 | Wrap flag for the coming edge (carry when counting up, borrow when counting down) |

## Verification
The bench covers both wrap points with the flag sampled in the cycle before the wrap. A table with an off-by-one word would either show the flag one code early or land on 10 or 15 instead of wrapping. It reverses direction at mid-count and at the edges of the decade, which catches a table indexed with swapped address halves. It also places codes above the decade into the register and expects a return to zero with a quiet flag; a table that leaves those words as plain increments would lock up or raise a false carry. Reset is asserted while the count is running, to show that it takes priority over the table.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  // Width of the count register; address of the table is this plus one.
  parameter int CNT_W = 4;

  // Word read out of the transition table for one clock.
  typedef struct packed {
    logic [CNT_W-1:0] nextState;
    logic             wrapFlag;
  } step_t;
endpackage

// File: rtl/dcnt_next_rom.sv
module dcnt_next_rom
  import dcnt_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic [CNT_W-1:0] stateQ,
  input  logic             countDown,
  output step_t            step
);
  localparam int ADDR_W = CNT_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SPAN   = 1 << CNT_W;

  // Computes one table word; address = {direction, present state}.
  function automatic step_t entryFor(int addr);
    step_t e;
    int    st;
    bit    dn;
    st = addr % SPAN;
    dn = ((addr / SPAN) % 2) == 1;
    e.wrapFlag = 1'b0;
    if (st >= MODULUS) begin
      e.nextState = '0;
    end else if (!dn) begin
      if (st == MODULUS - 1) begin
        e.nextState = '0;
        e.wrapFlag  = 1'b1;
      end else begin
        e.nextState = CNT_W'(st + 1);
      end
    end else begin
      if (st == 0) begin
        e.nextState = CNT_W'(MODULUS - 1);
        e.wrapFlag  = 1'b1;
      end else begin
        e.nextState = CNT_W'(st - 1);
      end
    end
    return e;
  endfunction

  step_t romWord [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign romWord[a] = entryFor(a);
  end

  logic [ADDR_W-1:0] romAddr;
  assign romAddr = {countDown, stateQ};
  assign step    = romWord[romAddr];
endmodule

// File: rtl/dcnt_state_reg.sv
module dcnt_state_reg
  import dcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  step_t            step,
  output logic [CNT_W-1:0] stateQ
);
  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= step.nextState;
  end
endmodule

// File: rtl/decade_rom_counter.sv
module decade_rom_counter
  import dcnt_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countDown,
  output logic [CNT_W-1:0] count,
  output logic             carry
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(MODULUS);

  step_t step;

  dcnt_next_rom #(.MODULUS(MODULUS)) u_rom (
    .stateQ    (count),
    .countDown (countDown),
    .step      (step)
  );

  dcnt_state_reg u_state (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .stateQ (count)
  );

  assign carry = step.wrapFlag;

  // R2: counting up inside the decade adds one
  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (!countDown && count < LAST) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R3: flag raised at 9 going up, and wrap to zero
  a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (!countDown && count == LAST) |-> carry ##1 (count == '0));

  // R4: counting down inside the decade subtracts one
  a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
    (countDown && count != '0 && count <= LAST) |=> (count == CNT_W'($past(count) - 1'b1)));

  // R5: flag raised at 0 going down, and wrap to the top code
  a_r5_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (countDown && count == '0) |-> carry ##1 (count == LAST));

  // R6: flag only at the two wrap points
  a_r6_flag_only_wrap: assert property (@(posedge clk) disable iff (rst)
    carry |-> ((!countDown && count == LAST) || (countDown && count == '0)));

  // R7: codes above the decade recover to zero without a flag
  a_r7_recover: assert property (@(posedge clk) disable iff (rst)
    (count >= TOP) |-> !carry ##1 (count == '0));
endmodule

// File: tb/decade_rom_counter_tb.sv
module decade_rom_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       countDown = 1'b0;
  logic [3:0] count;
  logic       carry;

  int nChecks = 0;
  int nFails  = 0;
  int expCount = 0;

  always #10 clk = ~clk;

  decade_rom_counter u_dut (
    .clk       (clk),
    .rst       (rst),
    .countDown (countDown),
    .count     (count),
    .carry     (carry)
  );

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int flagFor(int c, bit dn);
    return ((!dn && c == 9) || (dn && c == 0)) ? 1 : 0;
  endfunction

  // One clock: model advances, then outputs are checked away from the edge.
  task automatic tick(string req);
    int f;
    f = flagFor(expCount, countDown);
    check({req, " flag"}, int'(carry), f);
    @(posedge clk);
    if (rst) expCount = 0;
    else if (expCount > 9) expCount = 0;
    else if (!countDown) expCount = (expCount == 9) ? 0 : expCount + 1;
    else expCount = (expCount == 0) ? 9 : expCount - 1;
    @(negedge clk);
    #1;
    check({req, " count"}, int'(count), expCount);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    expCount = 0;
    @(negedge clk);
    #1;
    check("R1 reset", int'(count), 0);
    rst = 1'b0;
  endtask

  task automatic testUp();
    doReset();
    countDown = 1'b0;
    #1;
    for (int i = 0; i < 9; i++) tick("R2 up step");
    check("R3 flag at 9", int'(carry), 1);
    tick("R3 up wrap");
    check("R3 wrapped to 0", int'(count), 0);
    check("R6 no flag at 0 up", int'(carry), 0);
  endtask

  task automatic testDown();
    doReset();
    countDown = 1'b1;
    #1;
    check("R5 flag at 0", int'(carry), 1);
    tick("R5 down wrap");
    check("R5 wrapped to 9", int'(count), 9);
    check("R6 no flag at 9 down", int'(carry), 0);
    for (int i = 0; i < 9; i++) tick("R4 down step");
    check("R4 reached 0", int'(count), 0);
  endtask

  task automatic testReverse();
    doReset();
    countDown = 1'b0;
    #1;
    for (int i = 0; i < 5; i++) tick("R8 up leg");
    countDown = 1'b1;
    #1;
    check("R8 no flag mid", int'(carry), 0);
    for (int i = 0; i < 7; i++) tick("R8 down leg");
    countDown = 1'b0;
    #1;
    for (int i = 0; i < 3; i++) tick("R8 up again");
    check("R8 final count", int'(count), 1);
  endtask

  task automatic testResetPriority();
    doReset();
    countDown = 1'b0;
    #1;
    for (int i = 0; i < 9; i++) tick("R2 pre reset");
    rst = 1'b1;
    tick("R1 reset over wrap");
    check("R1 reset wins at 9", int'(count), 0);
    rst = 1'b0;
    countDown = 1'b1;
    #1;
    for (int i = 0; i < 3; i++) tick("R5 after reset");
    check("R1 then down", int'(count), 7);
  endtask

  task automatic testUnused(int code, bit dn);
    doReset();
    u_dut.u_state.stateQ = 4'(code);
    expCount = code;
    countDown = dn;
    #1;
    check("R7 code shown", int'(count), code);
    check("R7 flag low", int'(carry), 0);
    countDown = !dn;
    #1;
    check("R7 flag low other dir", int'(carry), 0);
    countDown = dn;
    #1;
    tick("R7 recover");
    check("R7 back to 0", int'(count), 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testUp();
    testDown();
    testReverse();
    testResetPriority();
    testUnused(10, 1'b0);
    testUnused(12, 1'b1);
    testUnused(15, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule